// File: doc/BRIEF.md
# Neural Functional Unit Pipeline

This block is the arithmetic core of a neural-network layer engine. In every accepted beat it takes a shared vector of `TI` neuron values and `TN` operand rows of `TI` values each, and reduces each row into one of `TN` output lanes in parallel. One datapath is shared by three layer kinds. Dot-product layers (classifier and convolution) multiply the shared vector element by element with each row, then sum the products in an adder tree. Max pooling and average pooling skip the multipliers and reduce each row directly, either with a tree of comparators or with the adder tree.

A layer's fan-in can be larger than `TI`, so it is fed as a series of chunks. A chunk flagged as first restarts each lane's wide accumulator. A chunk flagged as last releases the accumulated value. For average pooling that value is first shifted arithmetically right by a configured amount, which divides it by a power-of-two window. The value is then narrowed to the operand width with saturation and passed through an activation hook to a registered output. The hook is an identity here, because the real nonlinearity is a separate unit downstream.

Flow control is valid/ready on both sides. A stalled output freezes every stage, and no beat is dropped.

Top module: `nfu_pipe`

## Requirements
- R1: In dot-product mode (`in_mode` = 2'b00), output lane n (`out_data[n*DW +: DW]`) equals the sum, over every chunk from first to last, of `in_nrn[i*DW +: DW] * in_lane[(n*TI+i)*DW +: DW]` for all i. All values are signed two's complement, and the result is saturated to DW bits.
- R2: A chunk with `in_first` set discards what earlier chunks accumulated. Chunks without it add to (or, in max mode, compete with) the running value of each lane.
- R3: In max-pool mode (`in_mode` = 2'b01), lane n outputs the largest signed row value `in_lane[(n*TI+i)*DW +: DW]` seen over the chunks of the window. `in_nrn` has no effect on the result.
- R4: In average-pool mode (`in_mode` = 2'b10), lane n outputs the sum of its row values over the window, shifted arithmetically right by `in_shift` (the value held on the last chunk). This rounds toward minus infinity and ignores `in_nrn`.
- R5: A result above 2^(DW-1)-1 leaves as 2^(DW-1)-1, and a result below -2^(DW-1) leaves as -2^(DW-1).
- R6: Exactly one output beat is produced for each accepted chunk with `in_last` set, in acceptance order. Chunks without `in_last` produce none.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_valid` and `out_data` hold their values on the next cycle.
- R8: After reset, `out_valid` is low and `in_ready` is high.
- R9: Mode code 2'b11 behaves exactly like dot-product mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input chunk valid |
| in_ready | output | 1 | Unit can accept a chunk this cycle |
| in_first | input | 1 | Chunk restarts the lane accumulators |
| in_last | input | 1 | Chunk closes the window and releases a result |
| in_mode | input | 2 | 00 dot product, 01 max pool, 10 average pool, 11 as 00 |
| in_shift | input | SHW | Right-shift amount for average pooling |
| in_nrn | input | TI*DW | Shared neuron vector, element i at bits i*DW |
| in_lane | input | TN*TI*DW | Per-lane operand rows, lane n element i at (n*TI+i)*DW |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_data | output | TN*DW | Lane results, lane n at bits n*DW |

## Verification
The assertions rely on the environment keeping `in_valid` and the chunk fields constant only within a single handshake, and on chunk sequences that open each window with a first chunk before any last chunk. The stimulus sends every window as a first-flagged chunk followed by zero or more middle chunks and then a last-flagged chunk, and never changes inputs in the middle of an accept. The accumulator is wider than the worst-case sum of a few full-scale chunks, and the stimulus limits random windows to four chunks so that this width is never exceeded. Randomised output stalls and input gaps exercise the freeze path while the scoreboard confirms that no beat is lost or duplicated.

// File: rtl/nfu_pkg.sv
package nfu_pkg;

    localparam int SHW = 5;

    typedef enum logic [1:0] {
        NFU_DOT  = 2'b00,
        NFU_PMAX = 2'b01,
        NFU_PAVG = 2'b10,
        NFU_RSV  = 2'b11
    } nfu_mode_e;

    typedef struct packed {
        logic            first;
        logic            last;
        nfu_mode_e       mode;
        logic [SHW-1:0]  shift;
    } nfu_ctl_t;

    function automatic logic mode_is_pool(nfu_mode_e m);
        return (m == NFU_PMAX) || (m == NFU_PAVG);
    endfunction

    function automatic logic mode_is_max(nfu_mode_e m);
        return m == NFU_PMAX;
    endfunction

endpackage

// File: rtl/nfu_lane_mul.sv
module nfu_lane_mul #(
    parameter int DW = 16,
    parameter int TI = 4,
    parameter int AW = 38
) (
    input  logic [TI*DW-1:0] nrn_i,
    input  logic [TI*DW-1:0] row_i,
    input  logic             bypass_i,
    output logic [TI*AW-1:0] term_o
);
    localparam int PW = 2 * DW;

    for (genvar i = 0; i < TI; i++) begin : g_term
        logic signed [DW-1:0] a;
        logic signed [DW-1:0] b;
        logic signed [PW-1:0] prod;
        assign a    = nrn_i[i*DW +: DW];
        assign b    = row_i[i*DW +: DW];
        assign prod = a * b;
        always_comb begin
            if (bypass_i)
                term_o[i*AW +: AW] = {{(AW-DW){b[DW-1]}}, b};
            else
                term_o[i*AW +: AW] = {{(AW-PW){prod[PW-1]}}, prod};
        end
    end

endmodule

// File: rtl/nfu_reduce_tree.sv
module nfu_reduce_tree #(
    parameter int TI = 4,
    parameter int AW = 38
) (
    input  logic [TI*AW-1:0]     term_i,
    input  logic                 use_max_i,
    output logic signed [AW-1:0] red_o
);
    localparam int NODES = 2 * TI - 1;

    logic signed [AW-1:0] node [NODES];

    for (genvar i = 0; i < TI; i++) begin : g_leaf
        assign node[TI-1+i] = term_i[i*AW +: AW];
    end

    for (genvar k = 0; k < TI - 1; k++) begin : g_node
        always_comb begin
            if (use_max_i)
                node[k] = (node[2*k+1] > node[2*k+2]) ? node[2*k+1] : node[2*k+2];
            else
                node[k] = node[2*k+1] + node[2*k+2];
        end
    end

    assign red_o = node[0];

endmodule

// File: rtl/nfu_lane_acc.sv
module nfu_lane_acc
    import nfu_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 38
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 upd_i,
    input  nfu_ctl_t             ctl_i,
    input  logic signed [AW-1:0] red_i,
    output logic [DW-1:0]        res_o
);
    localparam logic signed [AW-1:0] MAXV = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [AW-1:0] MINV = ~MAXV;

    logic signed [AW-1:0] acc_q;
    logic signed [AW-1:0] acc_nx;
    logic signed [AW-1:0] scaled;

    always_comb begin
        if (ctl_i.first)
            acc_nx = red_i;
        else if (mode_is_max(ctl_i.mode))
            acc_nx = (red_i > acc_q) ? red_i : acc_q;
        else
            acc_nx = acc_q + red_i;
    end

    always_comb begin
        if (ctl_i.mode == NFU_PAVG)
            scaled = acc_nx >>> ctl_i.shift;
        else
            scaled = acc_nx;
        if (scaled > MAXV)
            res_o = MAXV[DW-1:0];
        else if (scaled < MINV)
            res_o = MINV[DW-1:0];
        else
            res_o = scaled[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (upd_i)
            acc_q <= acc_nx;
    end

endmodule

// File: rtl/nfu_act_hook.sv
module nfu_act_hook #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] x_i,
    output logic [DW-1:0] y_o
);
    assign y_o = x_i;

endmodule

// File: rtl/nfu_pipe.sv
module nfu_pipe
    import nfu_pkg::*;
#(
    parameter int DW = 16,
    parameter int TI = 4,
    parameter int TN = 2,
    parameter int GUARD = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 in_first,
    input  logic                 in_last,
    input  logic [1:0]           in_mode,
    input  logic [SHW-1:0]       in_shift,
    input  logic [TI*DW-1:0]     in_nrn,
    input  logic [TN*TI*DW-1:0]  in_lane,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [TN*DW-1:0]     out_data
);
    localparam int AW = 2 * DW + $clog2(TI) + GUARD;
    localparam int RW = TI * DW;
    localparam int TW = TI * AW;

    logic      adv;
    nfu_ctl_t  in_ctl;
    nfu_ctl_t  s1_ctl;
    nfu_ctl_t  s2_ctl;
    logic      s1_v;
    logic      s2_v;
    logic      bypass;

    logic [TN*TW-1:0]      term_c;
    logic [TN*TW-1:0]      s1_term;
    logic [TN*AW-1:0]      red_c;
    logic [TN*AW-1:0]      s2_red;
    logic [TN*DW-1:0]      res_c;
    logic [TN*DW-1:0]      act_c;

    assign adv      = !out_valid || out_ready;
    assign in_ready = adv;
    assign in_ctl   = '{first: in_first, last: in_last,
                        mode: nfu_mode_e'(in_mode), shift: in_shift};
    assign bypass   = mode_is_pool(nfu_mode_e'(in_mode));

    for (genvar n = 0; n < TN; n++) begin : g_lane
        nfu_lane_mul #(.DW(DW), .TI(TI), .AW(AW)) u_mul (
            .nrn_i    (in_nrn),
            .row_i    (in_lane[n*RW +: RW]),
            .bypass_i (bypass),
            .term_o   (term_c[n*TW +: TW])
        );

        nfu_reduce_tree #(.TI(TI), .AW(AW)) u_tree (
            .term_i    (s1_term[n*TW +: TW]),
            .use_max_i (mode_is_max(s1_ctl.mode)),
            .red_o     (red_c[n*AW +: AW])
        );

        nfu_lane_acc #(.DW(DW), .AW(AW)) u_acc (
            .clk   (clk),
            .rst   (rst),
            .upd_i (adv && s2_v),
            .ctl_i (s2_ctl),
            .red_i (s2_red[n*AW +: AW]),
            .res_o (res_c[n*DW +: DW])
        );

        nfu_act_hook #(.DW(DW)) u_act (
            .x_i (res_c[n*DW +: DW]),
            .y_o (act_c[n*DW +: DW])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v      <= 1'b0;
            s2_v      <= 1'b0;
            out_valid <= 1'b0;
            s1_ctl    <= '0;
            s2_ctl    <= '0;
            s1_term   <= '0;
            s2_red    <= '0;
            out_data  <= '0;
        end else if (adv) begin
            s1_v      <= in_valid;
            s1_ctl    <= in_ctl;
            s1_term   <= term_c;
            s2_v      <= s1_v;
            s2_ctl    <= s1_ctl;
            s2_red    <= red_c;
            out_valid <= s2_v && s2_ctl.last;
            if (s2_v && s2_ctl.last)
                out_data <= act_c;
        end
    end

endmodule

// File: rtl/nfu_pipe_chk.sv
module nfu_pipe_chk #(
    parameter int OW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ready,
    input logic          in_last,
    input logic          out_valid,
    input logic          out_ready,
    input logic [OW-1:0] out_data
);
    logic [3:0] pend;

    always_ff @(posedge clk) begin
        if (rst)
            pend <= '0;
        else
            pend <= pend + 4'(in_valid && in_ready && in_last)
                         - 4'(out_valid && out_ready);
    end

    a_r6_out_needs_last: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (pend != 4'd0));

    a_r7_stall_blocks_input: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    a_r7_hold_output: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r8_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && in_ready));

endmodule

bind nfu_pipe nfu_pipe_chk #(.OW(TN*DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/sim_nfu_pipe.sv
module sim_nfu_pipe;
    localparam int DW = 16;
    localparam int TI = 4;
    localparam int TN = 2;
    localparam int SHW = 5;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic                in_ready;
    logic                in_first = 1'b0;
    logic                in_last = 1'b0;
    logic [1:0]          in_mode = 2'b00;
    logic [SHW-1:0]      in_shift = '0;
    logic [TI*DW-1:0]    in_nrn = '0;
    logic [TN*TI*DW-1:0] in_lane = '0;
    logic                out_valid;
    logic                out_ready = 1'b1;
    logic [TN*DW-1:0]    out_data;

    nfu_pipe #(.DW(DW), .TI(TI), .TN(TN)) u0 (.*);

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int stall_pct = 0;
    bit done = 0;

    logic [TN*DW-1:0] exp_q[$];
    string            req_q[$];

    int xv [TI];
    int wv [TN][TI];
    longint acc_m [TN];

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic longint sat16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic send(input logic [1:0] mode, input bit first, input bit last,
                        input int shift, input string req);
        bit ok;
        logic [TN*DW-1:0] e;
        for (int n = 0; n < TN; n++) begin
            longint r;
            r = 0;
            for (int i = 0; i < TI; i++) begin
                if (mode == 2'b01) begin
                    if (i == 0 || longint'(wv[n][i]) > r) r = wv[n][i];
                end else if (mode == 2'b10) begin
                    r += wv[n][i];
                end else begin
                    r += longint'(xv[i]) * longint'(wv[n][i]);
                end
            end
            if (first) acc_m[n] = r;
            else if (mode == 2'b01) acc_m[n] = (r > acc_m[n]) ? r : acc_m[n];
            else acc_m[n] = acc_m[n] + r;
            if (mode == 2'b10) e[n*DW +: DW] = 16'(sat16(acc_m[n] >>> shift));
            else e[n*DW +: DW] = 16'(sat16(acc_m[n]));
        end
        if (last) begin
            exp_q.push_back(e);
            req_q.push_back(req);
        end
        @(negedge clk);
        in_mode  = mode;
        in_first = first;
        in_last  = last;
        in_shift = SHW'(shift);
        for (int i = 0; i < TI; i++) in_nrn[i*DW +: DW] = 16'(xv[i]);
        for (int n = 0; n < TN; n++)
            for (int i = 0; i < TI; i++) in_lane[(n*TI+i)*DW +: DW] = 16'(wv[n][i]);
        in_valid = 1'b1;
        forever begin
            #4;
            ok = in_ready;
            @(posedge clk);
            if (ok) break;
            @(negedge clk);
        end
        #1 in_valid = 1'b0;
    endtask

    function automatic int rnd16();
        return int'($urandom_range(0, 65535)) - 32768;
    endfunction

    // scoreboard monitor
    initial begin
        bit prev_stall = 0;
        logic [TN*DW-1:0] prev_data = '0;
        @(negedge clk);
        while (rst) @(negedge clk);
        forever begin
            @(negedge clk);
            out_ready = ($urandom_range(0, 99) >= stall_pct);
            #4;
            if (prev_stall) begin
                check(out_valid && out_data == prev_data, "R7 hold",
                      longint'(out_data), longint'(prev_data));
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R6 spurious output", longint'(out_data), 0);
                end else begin
                    logic [TN*DW-1:0] e;
                    string r;
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    for (int n = 0; n < TN; n++)
                        check(out_data[n*DW +: DW] == e[n*DW +: DW], r,
                              longint'($signed(out_data[n*DW +: DW])),
                              longint'($signed(e[n*DW +: DW])));
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
        end
    end

    // watchdog
    initial begin
        #(10 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R8 out_valid", longint'(out_valid), 0);
        check(in_ready == 1'b1, "R8 in_ready", longint'(in_ready), 1);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R8 out_valid after release", longint'(out_valid), 0);
        check(in_ready == 1'b1, "R8 in_ready after release", longint'(in_ready), 1);

        // R1 single chunk dot product
        xv = '{1, 2, 3, 4};
        wv[0] = '{1, 1, 1, 1};
        wv[1] = '{2, 0, -1, 1};
        send(2'b00, 1, 1, 0, "R1 single chunk");

        // R2 three-chunk accumulation, then a fresh window
        xv = '{5, -3, 7, 2};   wv[0] = '{3, 3, -2, 9};  wv[1] = '{-4, 1, 1, 1};
        send(2'b00, 1, 0, 0, "R2");
        xv = '{-8, 6, 1, 0};   wv[0] = '{2, 2, 2, 2};   wv[1] = '{7, -7, 7, -7};
        send(2'b00, 0, 0, 0, "R2");
        xv = '{100, 200, -300, 400}; wv[0] = '{1, -1, 1, -1}; wv[1] = '{0, 0, 0, 5};
        send(2'b00, 0, 1, 0, "R2 accumulate");
        xv = '{9, 9, 9, 9};    wv[0] = '{1, 0, 0, 0};   wv[1] = '{0, 0, 0, -1};
        send(2'b00, 1, 1, 0, "R2 first clears");

        // R3 max pooling with negatives, neurons vary and must not matter
        xv = '{32767, -32768, 1234, 0};
        wv[0] = '{-50, -7, -300, -8};  wv[1] = '{10, 400, -2, 399};
        send(2'b01, 1, 0, 0, "R3");
        xv = '{-1, -1, -1, -1};
        wv[0] = '{-9, -20, -6, -100};  wv[1] = '{-5, 3, 0, 1};
        send(2'b01, 0, 1, 0, "R3 max across chunks");

        // R4 average pooling, negative sum rounds toward minus infinity
        xv = '{7, 7, 7, 7};
        wv[0] = '{-1, -2, -3, -1};  wv[1] = '{8, 8, 8, 9};
        send(2'b10, 1, 1, 2, "R4 shift 2");
        xv = '{0, 0, 0, 0};
        wv[0] = '{32767, 32767, 32767, 32767}; wv[1] = '{-32768, -32768, -32768, -32768};
        send(2'b10, 1, 0, 0, "R4");
        send(2'b10, 0, 1, 3, "R4 two chunks shift 3");

        // R5 saturation both directions
        xv = '{32767, 32767, 32767, 32767};
        wv[0] = '{32767, 32767, 32767, 32767};
        wv[1] = '{-32768, -32768, -32768, -32768};
        send(2'b00, 1, 1, 0, "R5 saturate");
        wv[0] = '{0, 0, 0, 0};
        wv[1] = '{0, 0, 0, 1};
        xv = '{0, 0, 0, -32768};
        send(2'b10, 1, 1, 0, "R5 avg no shift in range");

        // R9 reserved mode acts as dot product
        xv = '{3, -4, 5, -6};
        wv[0] = '{2, 2, 2, 2};  wv[1] = '{-1, 1, -1, 1};
        send(2'b11, 1, 1, 0, "R9 reserved mode");

        // R6/R7 random windows with output stalls
        stall_pct = 40;
        for (int t = 0; t < 150; t++) begin
            int nc;
            logic [1:0] md;
            int sh;
            nc = int'($urandom_range(1, 4));
            md = 2'($urandom_range(0, 3));
            sh = int'($urandom_range(0, 31));
            for (int c = 0; c < nc; c++) begin
                for (int i = 0; i < TI; i++) xv[i] = rnd16();
                for (int n = 0; n < TN; n++)
                    for (int i = 0; i < TI; i++)
                        wv[n][i] = ($urandom_range(0, 3) == 0) ? rnd16()
                                   : int'($urandom_range(0, 200)) - 100;
                send(md, c == 0, c == nc - 1, sh, "R6 random window");
            end
            if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 5)) @(posedge clk);
        end

        stall_pct = 0;
        repeat (20) @(posedge clk);
        while (exp_q.size() != 0) @(posedge clk);
        repeat (10) @(posedge clk);
        check(exp_q.size() == 0, "R6 all results delivered", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule